// File: doc/BRIEF.md
# Four-pair conversion sequencer with shared busy/interrupt line

This block models the digital timing of a converter built from several channel pairs. Each pair has its own start input and a two-channel data word supplied from outside. A rising edge on a pair's start input captures that word and begins a conversion. The conversion runs for a fixed number of conversion-clock cycles. When it ends, the captured word moves into the pair's result register and the pair raises a one-cycle valid strobe. If auto-sleep is enabled, every conversion takes a few extra wake-up cycles.

All pairs share one status pin. In busy mode the pin is active while any pair is converting. It drops for one clock whenever a pair finishes while another is still running. In interrupt mode the pin goes active when a result is loaded and stays active until the next read access. A polarity input inverts the pin in either mode.

Pairs other than the first can be powered down, and starts sent to them are then ignored. A start on the first pair acts as a master start that returns the read pointer to channel 0 of pair 0. Each read access then steps the pointer through the channels in the order pair 0 ch0, pair 0 ch1, pair 1 ch0 and so on, wrapping back to the start.

Top module: `pairseq_ctrl`

## Requirements
- R1: A rising edge on `start_i[p]` is sampled at a clock edge. If pair p is idle and powered up, it is accepted at that edge. `done_o[p]` is then high for exactly one cycle, CONV_CYCLES clocks after the accepting edge. If several pairs are accepted at the same edge, they all complete together.
- R2: While `sleep_en_i` is 1 at the accepting edge, the conversion lasts CONV_CYCLES+WAKE_CYCLES clocks instead.
- R3: The result read for a pair equals the sample word present at its accepting edge. Later changes of `sample_i` do not alter it.
- R4: In busy mode, the level of the pin is active from the accepting edge until the last running pair completes, and inactive when no pair is running.
- R5: In busy mode, when a pair completes while another pair is still converting, the pin is inactive for exactly the one cycle in which `done_o` is high, and then active again.
- R6: A start edge on a pair that is already converting is ignored. Its completion time is unchanged and no second completion follows.
- R7: When `pwr_dn_i[p]` is 1 (pairs 1 and up), a start edge on pair p is ignored: the pin stays inactive and no `done_o` appears. Pair 0 has no power-down bit.
- R8: In interrupt mode (`int_mode_i`=1), the pin becomes active in the cycle `done_o` is high. It stays active until a clock edge with `rd_i`=1 and no completion. A completion at the same edge as a read keeps it active.
- R9: `pol_low_i`=1 inverts the pin, so the inactive level is 1.
- R10: An accepted start on pair 0 sets `rd_ptr_o` to 0, and takes priority over a read. A start on another pair leaves the pointer unchanged. Each `rd_i` edge advances the pointer by one, wrapping after channel 2*NUM_PAIRS-1. Channel c belongs to pair c/2, sub-channel c%2, and occupies `sample_i[c*DATA_W +: DATA_W]`.
- R11: `rd_data_o` reads 0 for a channel whose pair is powered down, and the stored result once it is powered up again.
- R12: After reset, no pair is converting, `done_o` is 0, `rd_ptr_o` is 0 and the pin is at its inactive level.
- R13: A start input held high counts as a single edge and does not restart the pair after it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | NUM_PAIRS | Per-pair start, rising-edge sensitive |
| pwr_dn_i | input | NUM_PAIRS-1 | Power-down for pairs 1 and up |
| sleep_en_i | input | 1 | Auto-sleep, adds wake-up cycles |
| int_mode_i | input | 1 | 0 = busy mode, 1 = interrupt mode |
| pol_low_i | input | 1 | Invert the status pin |
| rd_i | input | 1 | Read access strobe |
| sample_i | input | 2*NUM_PAIRS*DATA_W | Data words per channel |
| busy_int_o | output | 1 | Shared busy/interrupt pin |
| done_o | output | NUM_PAIRS | Per-pair result-valid strobe |
| rd_ptr_o | output | clog2(2*NUM_PAIRS) | Channel currently presented |
| rd_data_o | output | DATA_W | Result of that channel |

## Verification
The bench targets interleaved completions. A merge that only ORs the active flags would never show the one-cycle gap, and one that gates on the wrong cycle would put the gap one clock late. It re-triggers a pair that is still converting and holds a start high past completion. Either mistake would show up as a second strobe or a shifted first one. It also places a read at the same edge as a completion in interrupt mode, where clear-wins priority would drop the pin early. Finally, it starts a powered-down pair and checks that the pointer returns to channel 0 only on a pair-0 start; either error would raise the pin or scramble the read order.

// File: rtl/pairseq_pkg.sv
package pairseq_pkg;

   typedef enum logic {
      PIN_BUSY = 1'b0,
      PIN_INT  = 1'b1
   } pin_mode_e;

   // cycles a conversion occupies for a given sleep setting
   function automatic int unsigned conv_len(input int unsigned base,
                                            input int unsigned wake,
                                            input logic sleep);
      return sleep ? base + wake : base;
   endfunction

endpackage

// File: rtl/pairseq_pair_timer.sv
module pairseq_pair_timer #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CONV_CYCLES = 19,
   parameter int unsigned WAKE_CYCLES = 7,
   localparam int unsigned WORD_W     = 2 * DATA_W,
   localparam int unsigned CNT_W      = $clog2(CONV_CYCLES + WAKE_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_edge_i,
   input  logic              pwr_dn_i,
   input  logic              sleep_en_i,
   input  logic [WORD_W-1:0] sample_i,
   output logic              accept_o,
   output logic              active_o,
   output logic              done_o,
   output logic [WORD_W-1:0] result_o
);
   import pairseq_pkg::*;

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] held_q;
   logic [CNT_W-1:0]  load_len;

   assign load_len = CNT_W'(conv_len(CONV_CYCLES, WAKE_CYCLES, sleep_en_i));
   assign accept_o = start_edge_i & ~active_o & ~pwr_dn_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         done_o   <= 1'b0;
         cnt_q    <= '0;
         held_q   <= '0;
         result_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (accept_o) begin
            active_o <= 1'b1;
            cnt_q    <= load_len;
            held_q   <= sample_i;
         end else if (active_o) begin
            if (cnt_q == CNT_W'(1)) begin
               active_o <= 1'b0;
               done_o   <= 1'b1;
               result_o <= held_q;
            end else begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/pairseq_pin_merge.sv
module pairseq_pin_merge #(
   parameter int unsigned NUM_PAIRS = 4,
   parameter bit          REG_OUT   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PAIRS-1:0] active_i,
   input  logic [NUM_PAIRS-1:0] done_i,
   input  logic                 rd_i,
   input  logic                 int_mode_i,
   input  logic                 pol_low_i,
   output logic                 int_pend_o,
   output logic                 pin_o
);
   import pairseq_pkg::*;

   logic      busy_lvl;
   logic      int_lvl;
   logic      pin_raw;
   pin_mode_e mode;

   assign mode     = pin_mode_e'(int_mode_i);
   assign busy_lvl = (|active_i) & ~(|done_i);
   assign int_lvl  = int_pend_o | (|done_i);
   assign pin_raw  = ((mode == PIN_INT) ? int_lvl : busy_lvl) ^ pol_low_i;

   always_ff @(posedge clk) begin
      if (!rst_n)          int_pend_o <= 1'b0;
      else if (|done_i)    int_pend_o <= 1'b1;
      else if (rd_i)       int_pend_o <= 1'b0;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) pin_o <= pol_low_i;
            else        pin_o <= pin_raw;
         end
      end else begin : g_comb
         assign pin_o = pin_raw;
      end
   endgenerate

endmodule

// File: rtl/pairseq_readout.sv
module pairseq_readout #(
   parameter int unsigned NUM_PAIRS = 4,
   parameter int unsigned DATA_W    = 16,
   localparam int unsigned NUM_CH   = 2 * NUM_PAIRS,
   localparam int unsigned PTR_W    = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     master_i,
   input  logic                     rd_i,
   input  logic [NUM_PAIRS-1:0]     pd_i,
   input  logic [NUM_CH*DATA_W-1:0] results_i,
   output logic [PTR_W-1:0]         ptr_o,
   output logic [DATA_W-1:0]        data_o
);
   logic [NUM_CH-1:0] ch_off;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ch_off[c] = pd_i[c/2];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        ptr_o <= '0;
      else if (master_i) ptr_o <= '0;
      else if (rd_i)     ptr_o <= (ptr_o == PTR_W'(NUM_CH - 1)) ? '0 : ptr_o + PTR_W'(1);
   end

   always_comb begin
      data_o = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ptr_o == PTR_W'(c) && !ch_off[c]) data_o = results_i[c*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/pairseq_ctrl.sv
module pairseq_ctrl #(
   parameter int unsigned NUM_PAIRS   = 4,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CONV_CYCLES = 19,
   parameter int unsigned WAKE_CYCLES = 7,
   parameter bit          REG_OUT     = 1'b0,
   localparam int unsigned NUM_CH     = 2 * NUM_PAIRS,
   localparam int unsigned PTR_W      = $clog2(NUM_CH),
   localparam int unsigned WORD_W     = 2 * DATA_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_PAIRS-1:0]     start_i,
   input  logic [NUM_PAIRS-1:1]     pwr_dn_i,
   input  logic                     sleep_en_i,
   input  logic                     int_mode_i,
   input  logic                     pol_low_i,
   input  logic                     rd_i,
   input  logic [NUM_CH*DATA_W-1:0] sample_i,
   output logic                     busy_int_o,
   output logic [NUM_PAIRS-1:0]     done_o,
   output logic [PTR_W-1:0]         rd_ptr_o,
   output logic [DATA_W-1:0]        rd_data_o
);

   if (NUM_PAIRS < 2)   begin : g_bad_pairs $error("NUM_PAIRS must be at least 2"); end
   if (DATA_W < 1)      begin : g_bad_width $error("DATA_W must be at least 1"); end
   if (CONV_CYCLES < 2) begin : g_bad_conv  $error("CONV_CYCLES must be at least 2"); end

   logic [NUM_PAIRS-1:0]     start_q;
   logic [NUM_PAIRS-1:0]     start_edge;
   logic [NUM_PAIRS-1:0]     pd_eff;
   logic [NUM_PAIRS-1:0]     acc_vec;
   logic [NUM_PAIRS-1:0]     act_vec;
   logic [NUM_CH*DATA_W-1:0] res_bus;
   logic                     int_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) start_q <= '0;
      else        start_q <= start_i;
   end
   assign start_edge = start_i & ~start_q;

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      if (p == 0) begin : g_master
         assign pd_eff[p] = 1'b0;
      end else begin : g_slave
         assign pd_eff[p] = pwr_dn_i[p];
      end

      pairseq_pair_timer #(
         .DATA_W      (DATA_W),
         .CONV_CYCLES (CONV_CYCLES),
         .WAKE_CYCLES (WAKE_CYCLES)
      ) u_timer (
         .clk          (clk),
         .rst_n        (rst_n),
         .start_edge_i (start_edge[p]),
         .pwr_dn_i     (pd_eff[p]),
         .sleep_en_i   (sleep_en_i),
         .sample_i     (sample_i[p*WORD_W +: WORD_W]),
         .accept_o     (acc_vec[p]),
         .active_o     (act_vec[p]),
         .done_o       (done_o[p]),
         .result_o     (res_bus[p*WORD_W +: WORD_W])
      );
   end

   pairseq_pin_merge #(
      .NUM_PAIRS (NUM_PAIRS),
      .REG_OUT   (REG_OUT)
   ) u_merge (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (act_vec),
      .done_i     (done_o),
      .rd_i       (rd_i),
      .int_mode_i (int_mode_i),
      .pol_low_i  (pol_low_i),
      .int_pend_o (int_pend),
      .pin_o      (busy_int_o)
   );

   pairseq_readout #(
      .NUM_PAIRS (NUM_PAIRS),
      .DATA_W    (DATA_W)
   ) u_read (
      .clk       (clk),
      .rst_n     (rst_n),
      .master_i  (acc_vec[0]),
      .rd_i      (rd_i),
      .pd_i      (pd_eff),
      .results_i (res_bus),
      .ptr_o     (rd_ptr_o),
      .data_o    (rd_data_o)
   );

endmodule

// File: rtl/pairseq_ctrl_chk.sv
module pairseq_ctrl_chk #(
   parameter int unsigned NP = 4,
   parameter int unsigned PW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          int_mode_i,
   input logic          pol_low_i,
   input logic          busy_int_o,
   input logic          int_pend,
   input logic [NP-1:0] start_edge,
   input logic [NP-1:0] pd_eff,
   input logic [NP-1:0] acc_vec,
   input logic [NP-1:0] act_vec,
   input logic [NP-1:0] done_o,
   input logic [PW-1:0] rd_ptr_o
);

   for (genvar g = 0; g < NP; g++) begin : g_per
      // R1
      single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
         done_o[g] |=> !done_o[g]);
      // R1
      accept_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
         acc_vec[g] |=> act_vec[g]);
      // R7
      pd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (start_edge[g] && pd_eff[g] && !act_vec[g]) |=> !act_vec[g]);
   end

   // R4
   busy_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|act_vec) && !(|done_o) && !int_mode_i) |-> (busy_int_o != pol_low_i));

   // R12
   busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|act_vec) && !int_mode_i) |-> (busy_int_o == pol_low_i));

   // R8
   int_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|done_o) |=> int_pend);

   // R10
   master_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vec[0] |=> (rd_ptr_o == '0));

endmodule

bind pairseq_ctrl pairseq_ctrl_chk #(.NP(NUM_PAIRS), .PW(PTR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .int_mode_i (int_mode_i),
   .pol_low_i  (pol_low_i),
   .busy_int_o (busy_int_o),
   .int_pend   (int_pend),
   .start_edge (start_edge),
   .pd_eff     (pd_eff),
   .acc_vec    (acc_vec),
   .act_vec    (act_vec),
   .done_o     (done_o),
   .rd_ptr_o   (rd_ptr_o)
);

// File: tb/tb_pairseq_ctrl.sv
module tb_pairseq_ctrl;
   localparam int NP = 4;
   localparam int DW = 8;
   localparam int CV = 6;
   localparam int WK = 3;
   localparam int NW = 2 * NP;
   localparam int PW = $clog2(NW);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]    start = '0;
   logic [NP-1:1]    pwr = '0;
   logic             sleep = 1'b0, intm = 1'b0, pol = 1'b0, rd = 1'b0;
   logic [NW*DW-1:0] samp = '0;
   logic             pin;
   logic [NP-1:0]    done;
   logic [PW-1:0]    ptr;
   logic [DW-1:0]    rdata;

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pairseq_ctrl #(.NUM_PAIRS(NP), .DATA_W(DW), .CONV_CYCLES(CV), .WAKE_CYCLES(WK)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .pwr_dn_i(pwr), .sleep_en_i(sleep),
      .int_mode_i(intm), .pol_low_i(pol), .rd_i(rd), .sample_i(samp),
      .busy_int_o(pin), .done_o(done), .rd_ptr_o(ptr), .rd_data_o(rdata));

   function automatic logic [DW-1:0] pat(input int c);
      return DW'(8'h21 + c * 8'h13);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_rd();
      rd = 1'b1;
      tick();
      rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      // R12 reset state
      chk("R12 pin", pin, 0);
      chk("R12 done", done, 0);
      chk("R12 ptr", ptr, 0);
      rst_n = 1'b1;
      tick();

      // R1 / R13 sweep over every pair, start left high
      for (int p = 0; p < NP; p++) begin
         start[p] = 1'b1;
         for (int i = 1; i <= CV + 1; i++) begin
            tick();
            chk("R1 busy", pin, int'(i <= CV));
            chk("R1 done", done[p], int'(i == CV + 1));
         end
         for (int i = 1; i <= CV + 2; i++) begin
            tick();
            chk("R13 no retrigger", {pin, done}, 0);
         end
         start[p] = 1'b0;
         tick();
      end

      // R3 / R10 simultaneous start and read order
      for (int c = 0; c < NW; c++) samp[c*DW +: DW] = pat(c);
      pulse_rd();
      pulse_rd();
      chk("R10 advance", ptr, 2);
      start = '1;
      tick();
      chk("R10 master reset", ptr, 0);
      samp = {NW{8'hEE}};
      start = '0;
      for (int i = 2; i <= CV + 1; i++) tick();
      chk("R1 simultaneous done", done, 4'hF);
      chk("R4 all done", pin, 0);
      tick();
      chk("R4 idle after", pin, 0);
      for (int c = 0; c < NW; c++) begin
         chk("R3 held data", rdata, pat(c));
         chk("R10 order", ptr, c);
         pulse_rd();
      end
      chk("R10 wrap", ptr, 0);
      pulse_rd();
      start[1] = 1'b1;
      tick();
      chk("R10 non-master keeps ptr", ptr, 1);
      start[1] = 1'b0;
      for (int i = 1; i <= CV + 1; i++) tick();

      // R2 auto-sleep length
      sleep = 1'b1;
      start[2] = 1'b1;
      for (int i = 1; i <= CV + WK + 1; i++) begin
         tick();
         chk("R2 busy", pin, int'(i <= CV + WK));
         chk("R2 done", done[2], int'(i == CV + WK + 1));
      end
      start[2] = 1'b0;
      sleep = 1'b0;
      tick();

      // R5 interleaved completions
      start[0] = 1'b1;
      for (int i = 1; i <= CV + 4; i++) begin
         bit a_act, b_act, a_dn, b_dn;
         tick();
         a_act = (i <= CV);
         b_act = (i >= 3) && (i <= CV + 2);
         a_dn  = (i == CV + 1);
         b_dn  = (i == CV + 3);
         chk("R5 busy gap", pin, int'((a_act | b_act) & !(a_dn | b_dn)));
         if (i == 2) start[1] = 1'b1;
      end
      start = '0;
      tick();

      // R6 restart while converting
      start[3] = 1'b1;
      for (int i = 1; i <= 2 * CV + 3; i++) begin
         tick();
         chk("R6 single completion", done[3], int'(i == CV + 1));
         if (i == 2) start[3] = 1'b0;
         if (i == 3) start[3] = 1'b1;
      end
      start = '0;
      tick();

      // R7 powered-down pair
      pwr[1] = 1'b1;
      start[1] = 1'b1;
      for (int i = 1; i <= CV + 2; i++) begin
         tick();
         chk("R7 ignored start", {pin, done}, 0);
      end
      start = '0;
      tick();
      start[0] = 1'b1;
      for (int i = 1; i <= CV + 1; i++) begin
         tick();
         chk("R7 pair0 runs", done[0], int'(i == CV + 1));
      end
      start = '0;
      tick();

      // R11 powered-down readout
      pulse_rd();
      pulse_rd();
      chk("R11 ptr at pair1 ch0", ptr, 2);
      chk("R11 zero while off", rdata, 0);
      pwr = '0;
      tick();
      chk("R11 restored", rdata, 8'hEE);

      // R8 interrupt mode, read at the completion edge
      intm = 1'b1;
      rd = 1'b1;
      start[3] = 1'b1;
      for (int i = 1; i <= CV + 3; i++) begin
         tick();
         chk("R8 set wins", pin, int'(i == CV + 1 || i == CV + 2));
      end
      rd = 1'b0;
      start = '0;
      tick();
      start[3] = 1'b1;
      for (int i = 1; i <= CV + 4; i++) begin
         tick();
         chk("R8 latched", pin, int'(i >= CV + 1));
      end
      pulse_rd();
      chk("R8 cleared by read", pin, 0);
      start = '0;
      intm = 1'b0;
      tick();

      // R9 inverted polarity
      pol = 1'b1;
      tick();
      chk("R9 idle high", pin, 1);
      start[0] = 1'b1;
      for (int i = 1; i <= CV + 1; i++) begin
         tick();
         chk("R9 active low", pin, int'(i > CV));
      end
      start = '0;
      pol = 1'b0;
      tick();

      finish_run();
   end
endmodule